// File: doc/BRIEF.md
# Prioritised Interrupt Line Controller Register Bank

This block gathers up to 32 level interrupt request lines behind a small word-addressed register bus. Each line has an enable bit, a pending bit, an active bit and a 2-bit urgency level. Software turns enable and pending bits on and off only through paired write-one-to-set and write-one-to-clear registers, so a write never disturbs bits it does not name. A rising edge on a request line also marks that line pending.

Every cycle the block looks at all lines that are both enabled and pending. It reports the most urgent one, meaning the lowest level value with ties going to the lower line number, together with a valid flag and the winning level. The core acknowledges the reported line, which moves it from pending to active. The core later signals end of service, which drops the active bit of the line it last acknowledged. Reads are combinational from the address. Writes take effect at the next clock edge.

Top module: `irq_ctrl_bank`

## Requirements
- R1: After reset every enable, pending and active bit and every level field reads 0, and sel_valid_o is 0.
- R2: A write to offset 0x000 sets the enable bit of each line whose data bit is 1. A write to 0x180 clears the enable bit of each line whose data bit is 1. Data bits of 0 change nothing. Both offsets read back the enable bits, with bit i for line i.
- R3: A write to 0x200 makes each line whose data bit is 1 pending, even when that line is disabled. A line that is already pending stays pending. Both 0x200 and 0x280 read back the pending bits.
- R4: A write to 0x280 clears the pending bit of each line whose data bit is 1, and leaves every active bit unchanged.
- R5: The level registers sit at 0x400+4n for n=0..7. Byte k (bits 8k+7:8k) of register n belongs to line 4n+k. Only bits 8k+7:8k+6 are stored, and the other six bits read 0, so a written 0xFF reads back as 0xC0.
- R6: A 0-to-1 transition on irq_i[i] sets pending bit i. A request held high does not set it again after a clear. When a clear-pending write and a rising edge hit the same line in one cycle, the line ends up pending.
- R7: sel_valid_o is 1 exactly when some line is both enabled and pending. sel_id_o is then the line with the lowest level value, ties going to the lowest line number, and sel_prio_o is that line's 2-bit level. A pending line that is disabled is never reported.
- R8: An ack_i pulse while sel_valid_o is 1 clears the pending bit of the reported line and sets its active bit. An ack_i pulse while sel_valid_o is 0 changes nothing.
- R9: An eos_i pulse clears the active bit of the line most recently acknowledged.
- R10: Offset 0x300 reads the active bits, and writes to it are ignored. Any other unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 12 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_i | input | 32 | Level interrupt requests |
| ack_i | input | 1 | Core accepts the reported line |
| eos_i | input | 1 | Core finished the acknowledged line |
| sel_id_o | output | 5 | Reported line number |
| sel_valid_o | output | 1 | A line is reported |
| sel_prio_o | output | 2 | Level of the reported line |

## Verification
The bench builds the block with its defaults: 32 lines and 2-bit levels in 8-bit fields. With these values the top line 31 sits in the top bit of the set and clear words. All eight level registers are decodable, and writing 0xFF shows the drop to 0xC0. A register table walk covers the set/clear pairs. Directed tests then cover level ordering, ties, disabled lines that are pending, acknowledge and end of service, and a clear-pending write colliding with a rising request edge.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam logic [11:0] OFS_SET_EN  = 12'h000;
  localparam logic [11:0] OFS_CLR_EN  = 12'h180;
  localparam logic [11:0] OFS_SET_PND = 12'h200;
  localparam logic [11:0] OFS_CLR_PND = 12'h280;
  localparam logic [11:0] OFS_ACT     = 12'h300;
  localparam logic [11:0] OFS_PRIO    = 12'h400;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_SET_EN,
    REG_CLR_EN,
    REG_SET_PND,
    REG_CLR_PND,
    REG_ACT,
    REG_PRIO
  } reg_sel_e;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [ADDR_W-1:0] PRIO_LO = ADDR_W'(OFS_PRIO);
  localparam logic [ADDR_W-1:0] PRIO_HI = ADDR_W'(OFS_PRIO + 4 * NUM_REGS);

  always_comb begin
    sel_o = REG_NONE;
    idx_o = addr_i[2 +: IDX_W];
    if (addr_i[1:0] == 2'b00) begin
      if      (addr_i == ADDR_W'(OFS_SET_EN))  sel_o = REG_SET_EN;
      else if (addr_i == ADDR_W'(OFS_CLR_EN))  sel_o = REG_CLR_EN;
      else if (addr_i == ADDR_W'(OFS_SET_PND)) sel_o = REG_SET_PND;
      else if (addr_i == ADDR_W'(OFS_CLR_PND)) sel_o = REG_CLR_PND;
      else if (addr_i == ADDR_W'(OFS_ACT))     sel_o = REG_ACT;
      else if (addr_i >= PRIO_LO && addr_i < PRIO_HI) sel_o = REG_PRIO;
    end
  end
endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_i;
  end

  assign rise_o = irq_i & ~irq_q;
endmodule

// File: rtl/irq_prio_regs.sv
module irq_prio_regs #(
  parameter int N        = 32,
  parameter int PW       = 2,
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3,
  parameter int FIELD_W  = 8,
  parameter int DATA_W   = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [3:0][PW-1:0]    fld_i,
  output logic [N-1:0][PW-1:0]  prio_o,
  output logic [DATA_W-1:0]     rd_word_o
);
  logic [N-1:0][PW-1:0] prio_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        prio_q[i] <= '0;
      else if (we_i && idx_i == IDX_W'(i / 4))
        prio_q[i] <= fld_i[i % 4];
    end
  end

  // stored bits land at the top of each byte field, the rest read 0
  always_comb begin
    rd_word_o = '0;
    for (int i = 0; i < N; i++) begin
      if (idx_i == IDX_W'(i / 4))
        rd_word_o[(i % 4) * FIELD_W + FIELD_W - 1 -: PW] = prio_q[i];
    end
  end

  assign prio_o = prio_q;
endmodule

// File: rtl/irq_line_state.sv
module irq_line_state #(
  parameter int N    = 32,
  parameter int ID_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    set_en_i,
  input  logic [N-1:0]    clr_en_i,
  input  logic [N-1:0]    set_pnd_i,
  input  logic [N-1:0]    clr_pnd_i,
  input  logic [N-1:0]    rise_i,
  input  logic            ack_i,
  input  logic            eos_i,
  input  logic            sel_valid_i,
  input  logic [ID_W-1:0] sel_id_i,
  output logic [N-1:0]    en_o,
  output logic [N-1:0]    pnd_o,
  output logic [N-1:0]    act_o
);
  logic [N-1:0]    en_q, pnd_q, act_q;
  logic [N-1:0]    ack_mask, eos_mask;
  logic            svc_q;
  logic [ID_W-1:0] svc_id_q;
  logic            ack_fire;

  assign ack_fire = ack_i & sel_valid_i;
  assign ack_mask = ack_fire ? (N'(1) << sel_id_i) : '0;
  assign eos_mask = (eos_i && svc_q) ? (N'(1) << svc_id_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      pnd_q    <= '0;
      act_q    <= '0;
      svc_q    <= 1'b0;
      svc_id_q <= '0;
    end else begin
      en_q  <= (en_q | set_en_i) & ~clr_en_i;
      // hardware edge beats any clear in the same cycle
      pnd_q <= ((pnd_q | set_pnd_i) & ~clr_pnd_i & ~ack_mask) | rise_i;
      act_q <= (act_q & ~eos_mask) | ack_mask;
      if (ack_fire) begin
        svc_q    <= 1'b1;
        svc_id_q <= sel_id_i;
      end else if (eos_i) begin
        svc_q    <= 1'b0;
      end
    end
  end

  assign en_o  = en_q;
  assign pnd_o = pnd_q;
  assign act_o = act_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N    = 32,
  parameter int PW   = 2,
  parameter int ID_W = 5
) (
  input  logic [N-1:0]          cand_i,
  input  logic [N-1:0][PW-1:0]  prio_i,
  output logic                  valid_o,
  output logic [ID_W-1:0]       id_o,
  output logic [PW-1:0]         prio_o
);
  // strict less-than keeps the lower index on ties
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    prio_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (!valid_o || prio_i[i] < prio_o)) begin
        valid_o = 1'b1;
        id_o    = ID_W'(i);
        prio_o  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_ctrl_bank.sv
module irq_ctrl_bank
  import irq_bank_pkg::*;
#(
  parameter  int NUM_IRQ = 32,
  parameter  int ADDR_W  = 12,
  parameter  int DATA_W  = 32,
  parameter  int PRIO_W  = 2,
  localparam int ID_W    = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  input  logic               bus_we_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               ack_i,
  input  logic               eos_i,
  output logic [ID_W-1:0]    sel_id_o,
  output logic               sel_valid_o,
  output logic [PRIO_W-1:0]  sel_prio_o
);
  localparam int FIELD_W  = DATA_W / 4;
  localparam int NUM_REGS = (NUM_IRQ + 3) / 4;
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  reg_sel_e                    reg_sel;
  logic [IDX_W-1:0]            prio_idx;
  logic [NUM_IRQ-1:0]          wr_bits;
  logic [NUM_IRQ-1:0]          set_en, clr_en, set_pnd, clr_pnd;
  logic [NUM_IRQ-1:0]          rise, en_q, pnd_q, act_q;
  logic [3:0][PRIO_W-1:0]      prio_fld;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio;
  logic [DATA_W-1:0]           prio_rd;
  logic                        prio_we;

  irq_bus_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
  ) u_dec (
    .addr_i(bus_addr_i), .sel_o(reg_sel), .idx_o(prio_idx)
  );

  assign wr_bits = bus_wdata_i[NUM_IRQ-1:0];
  assign set_en  = (bus_we_i && reg_sel == REG_SET_EN)  ? wr_bits : '0;
  assign clr_en  = (bus_we_i && reg_sel == REG_CLR_EN)  ? wr_bits : '0;
  assign set_pnd = (bus_we_i && reg_sel == REG_SET_PND) ? wr_bits : '0;
  assign clr_pnd = (bus_we_i && reg_sel == REG_CLR_PND) ? wr_bits : '0;
  assign prio_we = bus_we_i && reg_sel == REG_PRIO;

  for (genvar k = 0; k < 4; k++) begin : g_fld
    assign prio_fld[k] = bus_wdata_i[k * FIELD_W + FIELD_W - 1 -: PRIO_W];
  end

  irq_edge_detect #(.N(NUM_IRQ)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .rise_o(rise)
  );

  irq_line_state #(.N(NUM_IRQ), .ID_W(ID_W)) u_state (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_en_i(set_en), .clr_en_i(clr_en),
    .set_pnd_i(set_pnd), .clr_pnd_i(clr_pnd),
    .rise_i(rise), .ack_i(ack_i), .eos_i(eos_i),
    .sel_valid_i(sel_valid_o), .sel_id_i(sel_id_o),
    .en_o(en_q), .pnd_o(pnd_q), .act_o(act_q)
  );

  irq_prio_regs #(
    .N(NUM_IRQ), .PW(PRIO_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W),
    .FIELD_W(FIELD_W), .DATA_W(DATA_W)
  ) u_prio (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(prio_we), .idx_i(prio_idx),
    .fld_i(prio_fld), .prio_o(prio), .rd_word_o(prio_rd)
  );

  irq_pick #(.N(NUM_IRQ), .PW(PRIO_W), .ID_W(ID_W)) u_pick (
    .cand_i(en_q & pnd_q), .prio_i(prio),
    .valid_o(sel_valid_o), .id_o(sel_id_o), .prio_o(sel_prio_o)
  );

  always_comb begin
    unique case (reg_sel)
      REG_SET_EN, REG_CLR_EN:   bus_rdata_o = DATA_W'(en_q);
      REG_SET_PND, REG_CLR_PND: bus_rdata_o = DATA_W'(pnd_q);
      REG_ACT:                  bus_rdata_o = DATA_W'(act_q);
      REG_PRIO:                 bus_rdata_o = prio_rd;
      default:                  bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_bank_sva.sv
module irq_bank_sva #(
  parameter int N      = 32,
  parameter int PW     = 2,
  parameter int ID_W   = 5,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ADDR_W-1:0]    bus_addr_i,
  input logic                 bus_we_i,
  input logic [DATA_W-1:0]    bus_rdata_o,
  input logic                 ack_i,
  input logic                 eos_i,
  input logic [N-1:0]         rise,
  input logic [N-1:0]         en_q,
  input logic [N-1:0]         pnd_q,
  input logic [N-1:0]         act_q,
  input logic [N-1:0][PW-1:0] prio,
  input logic                 sel_valid_o,
  input logic [ID_W-1:0]      sel_id_o,
  input logic [PW-1:0]        sel_prio_o
);
  logic better;
  always_comb begin
    better = 1'b0;
    for (int i = 0; i < N; i++)
      if (en_q[i] && pnd_q[i] &&
          (prio[i] < sel_prio_o || (prio[i] == sel_prio_o && ID_W'(i) < sel_id_o)))
        better = 1'b1;
  end

  p_sel_is_cand_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> (en_q[sel_id_o] && pnd_q[sel_id_o] && prio[sel_id_o] == sel_prio_o));
  p_no_better_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> !better);
  p_valid_any_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(en_q & pnd_q)) |-> sel_valid_o);
  p_ack_moves_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && sel_valid_o) |=>
      (act_q[$past(sel_id_o)] && (!pnd_q[$past(sel_id_o)] || $past(rise[sel_id_o]))));
  p_rise_pends_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0) |=> ((pnd_q & $past(rise)) == $past(rise)));
  p_prio_low_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i[11:10] == 2'b01 && bus_addr_i[9:5] == '0) |->
      ((bus_rdata_o & 32'h3F3F3F3F) == '0));
  p_clrpnd_keeps_act_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == 12'h280 && !ack_i && !eos_i) |=> act_q == $past(act_q));
  p_en_only_by_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && (bus_addr_i == 12'h000 || bus_addr_i == 12'h180)) |=> $stable(en_q));
endmodule

bind irq_ctrl_bank irq_bank_sva #(
  .N(NUM_IRQ), .PW(PRIO_W), .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i),
  .bus_rdata_o(bus_rdata_o), .ack_i(ack_i), .eos_i(eos_i), .rise(rise),
  .en_q(en_q), .pnd_q(pnd_q), .act_q(act_q), .prio(prio),
  .sel_valid_o(sel_valid_o), .sel_id_o(sel_id_o), .sel_prio_o(sel_prio_o)
);

// File: tb/sim_irq_ctrl_bank.sv
`timescale 1ns/1ps
module sim_irq_ctrl_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [31:0] irq = '0;
  logic        ack = 1'b0;
  logic        eos = 1'b0;
  logic [4:0]  sel_id;
  logic        sel_valid;
  logic [1:0]  sel_prio;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  irq_ctrl_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_we_i(we), .bus_rdata_o(rdata), .irq_i(irq), .ack_i(ack), .eos_i(eos),
    .sel_id_o(sel_id), .sel_valid_o(sel_valid), .sel_prio_o(sel_prio)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h000, 32'h0,         32'h0},          // R1
    '{1'b1, 12'h000, 32'h0000_00F0, 32'h0},
    '{1'b0, 12'h180, 32'h0,         32'h0000_00F0},  // R2
    '{1'b1, 12'h180, 32'h0000_0030, 32'h0},
    '{1'b0, 12'h000, 32'h0,         32'h0000_00C0},  // R2
    '{1'b1, 12'h200, 32'h8000_0001, 32'h0},
    '{1'b0, 12'h280, 32'h0,         32'h8000_0001},  // R3
    '{1'b1, 12'h200, 32'h0000_0001, 32'h0},
    '{1'b0, 12'h200, 32'h0,         32'h8000_0001},  // R3
    '{1'b1, 12'h280, 32'h8000_0000, 32'h0},
    '{1'b0, 12'h200, 32'h0,         32'h0000_0001},  // R4
    '{1'b1, 12'h404, 32'hFF7F_4001, 32'h0},
    '{1'b0, 12'h404, 32'h0,         32'hC040_4000},  // R5
    '{1'b0, 12'h41C, 32'h0,         32'h0},          // R5
    '{1'b1, 12'h300, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 12'h300, 32'h0,         32'h0},          // R10
    '{1'b0, 12'h104, 32'h0,         32'h0}           // R10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic pulse_eos();
    @(negedge clk); eos = 1'b1;
    @(negedge clk); eos = 1'b0;
  endtask

  task automatic check_sel(input string req, input logic v, input logic [4:0] id, input logic [1:0] p);
    #1;
    check({req, " valid"}, 32'(sel_valid), 32'(v));
    if (v) begin
      check({req, " id"}, 32'(sel_id), 32'(id));
      check({req, " prio"}, 32'(sel_prio), 32'(p));
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    #1 check("R1 valid after reset", 32'(sel_valid), 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].a, VEC[i].d);
      else begin
        rd(VEC[i].a, d);
        check($sformatf("R1-table entry %0d", i), d, VEC[i].exp);
      end
    end

    // levels: line4=0 line5=1 line6=1 line7=3; enabled 6,7; pending 0 (disabled)
    check_sel("R7 disabled pending", 1'b0, 5'd0, 2'd0);
    wr(12'h200, 32'h0000_00C0);
    check_sel("R7 lower value wins", 1'b1, 5'd6, 2'd1);
    wr(12'h000, 32'h0000_0020);
    wr(12'h200, 32'h0000_0020);
    check_sel("R7 tie lower index", 1'b1, 5'd5, 2'd1);
    wr(12'h000, 32'h0000_0001);
    check_sel("R7 level zero", 1'b1, 5'd0, 2'd0);

    pulse_ack();
    rd(12'h200, d); check("R8 ack clears pending", d, 32'h0000_00E0);
    rd(12'h300, d); check("R8 ack sets active", d, 32'h0000_0001);
    check_sel("R8 next selection", 1'b1, 5'd5, 2'd1);

    wr(12'h200, 32'h0000_0001);
    check_sel("R3 re-pend selected", 1'b1, 5'd0, 2'd0);
    wr(12'h280, 32'h0000_0001);
    rd(12'h300, d); check("R4 active kept", d, 32'h0000_0001);
    rd(12'h280, d); check("R4 pending cleared", d, 32'h0000_00E0);

    pulse_eos();
    rd(12'h300, d); check("R9 eos clears active", d, 32'h0);

    wr(12'h280, 32'hFFFF_FFFF);
    check_sel("R7 none pending", 1'b0, 5'd0, 2'd0);
    pulse_ack();
    rd(12'h300, d); check("R8 idle ack ignored", d, 32'h0);
    rd(12'h200, d); check("R8 idle ack pending", d, 32'h0);

    @(negedge clk); irq[9] = 1'b1;
    rd(12'h200, d); check("R6 rising edge pends", d, 32'h0000_0200);
    wr(12'h280, 32'h0000_0200);
    rd(12'h200, d); check("R6 held level no re-pend", d, 32'h0);
    @(negedge clk); irq[9] = 1'b0;
    @(negedge clk);
    addr = 12'h280; wdata = 32'h0000_0200; we = 1'b1; irq[9] = 1'b1;
    @(negedge clk); we = 1'b0;
    rd(12'h200, d); check("R6 edge beats clear", d, 32'h0000_0200);
    wr(12'h000, 32'h0000_0200);
    rd(12'h180, d); check("R2 enable read via clear", d, 32'h0000_02E1);
    check_sel("R7 line nine", 1'b1, 5'd9, 2'd0);

    done = 1'b1;
    finish_run();
  end
endmodule